// File: doc/BRIEF.md
# Sector Erase Batching Window

This block sits on the device side of a flash array controller, right after the command decoder. When a complete sector erase command arrives, the block opens an acceptance window. During that window it collects further single-write sector erase requests into a per-sector bit mask. Every write that starts inside the window pushes the deadline back. Once the window has been quiet for its full length, the block fires a one-cycle erase-start pulse. The erase engine then works on every sector named in the mask.

The decoder presents each sector erase request as a one-cycle pulse carrying a sector number. That number is the value of address bits 16 down to 14, so each sector spans a contiguous run of 16K locations. The decoder also pulses a foreign-command input for any other recognised command, and a write-strobe input at the start of every bus write. A foreign command inside the window throws away the collected batch and signals an abort. While the erase runs, every command is ignored until the engine reports completion on the done input. The window length is a parameter computed as clock frequency (MHz) times window length (µs), which gives 8000 cycles for 80 µs at 100 MHz.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `sector_mask` is 0 and `window_open`, `erase_active`, `erase_start` and `abort` are all 0.
- R2: A `se_cmd` pulse while neither a window nor an erase is in progress opens the window on the next cycle, with `sector_mask` holding only bit `se_sector` (bit k stands for sector number k).
- R3: A `se_cmd` pulse while the window is open sets bit `se_sector` in `sector_mask`, keeps all bits already set, and restarts the window timer.
- R4: A `se_cmd` pulse naming a sector already in the mask leaves `sector_mask` unchanged but restarts the window timer.
- R5: The window stays open for exactly WIN_CYCLES cycles after the last accepted request or restart. On the next edge, `window_open` falls, `erase_active` rises and `erase_start` is high for exactly one cycle.
- R6: A `wr_strobe` pulse alone while the window is open restarts the window timer without changing the mask.
- R7: An `other_cmd` pulse while the window is open produces a one-cycle `abort`, clears `sector_mask` and closes the window without starting an erase. It takes priority over a `se_cmd` in the same cycle and over expiry on the last window cycle.
- R8: While `erase_active` is 1, `se_cmd`, `other_cmd` and `wr_strobe` have no effect on any output. `erase_done` then clears the mask and `erase_active` on the next cycle.
- R9: The status bit `erase_active` reads 0 while the window is open and 1 from the erase start until completion.
- R10: With neither a window nor an erase in progress, `other_cmd`, `wr_strobe` and `erase_done` have no effect: all outputs stay at their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| se_cmd | input | 1 | One-cycle sector erase request from the decoder |
| se_sector | input | SEC_W (3) | Sector number of the request (address bits 16..14) |
| other_cmd | input | 1 | One-cycle pulse for any command other than sector erase |
| wr_strobe | input | 1 | One-cycle pulse at the start of any bus write |
| erase_done | input | 1 | Erase engine completion pulse |
| sector_mask | output | N_SECTORS (8) | Pending set of sectors to erase |
| erase_start | output | 1 | One-cycle pulse launching the erase |
| window_open | output | 1 | High while further sectors may be appended |
| erase_active | output | 1 | Status bit: 0 while the window is open, 1 while erasing |
| abort | output | 1 | One-cycle pulse when a foreign command discards the batch |

## Verification
The assertions assume the decoder's inputs are single-cycle pulses and that `se_sector` is valid whenever `se_cmd` is high. They also assume `erase_done` comes only from an engine that has been started, although stray pulses elsewhere are tolerated and checked as having no effect. The stimulus drives each input for one cycle at a time, changes it only between edges, and asserts `erase_done` only after a start, except for the single deliberate idle pulse. The window length is shortened through the frequency and duration parameters, so that expiry, restart and abort on the last window cycle can all be reached in a few cycles.

// File: rtl/sewa_pkg.sv
package sewa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sewa_state_e;

  // Window length in clock cycles: MHz times microseconds.
  function automatic int window_cycles(input int clk_mhz, input int win_us);
    return clk_mhz * win_us;
  endfunction

  // Counter width able to hold the value n.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sewa_timer.sv
module sewa_timer #(
  parameter int WIN_CYCLES = 8000,
  parameter int CW         = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam logic [CW-1:0] LOAD_V = CW'(WIN_CYCLES);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= LOAD_V;
    else if (run && cnt_q != '0)     cnt_q <= cnt_q - ONE_V;
  end

  assign expire = run && !load && (cnt_q == ONE_V);
endmodule

// File: rtl/sewa_mask.sv
module sewa_mask #(
  parameter int N_SECTORS = 8,
  parameter int SEC_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 set,
  input  logic [SEC_W-1:0]     idx,
  output logic [N_SECTORS-1:0] mask
);
  for (genvar i = 0; i < N_SECTORS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                               mask[i] <= 1'b0;
      else if (clr)                             mask[i] <= 1'b0;
      else if (set && idx == SEC_W'(i))         mask[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sewa_ctrl.sv
module sewa_ctrl
  import sewa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic se_cmd,
  input  logic other_cmd,
  input  logic wr_strobe,
  input  logic erase_done,
  input  logic expire,
  output logic ev_accept,
  output logic ev_add,
  output logic ev_restart,
  output logic ev_abort,
  output logic ev_launch,
  output logic timer_load,
  output logic timer_run,
  output logic mask_set,
  output logic mask_clr,
  output logic window_open,
  output logic erase_active,
  output logic erase_start,
  output logic abort
);
  sewa_state_e state_q, state_d;

  logic in_idle, in_window, in_erase;
  assign in_idle   = (state_q == ST_IDLE);
  assign in_window = (state_q == ST_WINDOW);
  assign in_erase  = (state_q == ST_ERASE);

  // Named events, brought out for the checker.
  assign ev_accept  = in_idle && se_cmd;
  assign ev_abort   = in_window && other_cmd;
  assign ev_add     = in_window && se_cmd && !other_cmd;
  assign ev_restart = in_window && wr_strobe && !other_cmd;
  assign ev_launch  = expire && !ev_abort;

  assign timer_load = ev_accept || ev_add || ev_restart;
  assign timer_run  = in_window;
  assign mask_set   = ev_accept || ev_add;
  assign mask_clr   = ev_abort || (in_erase && erase_done);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (se_cmd) state_d = ST_WINDOW;
      ST_WINDOW: begin
        if (ev_abort)       state_d = ST_IDLE;
        else if (ev_launch) state_d = ST_ERASE;
      end
      ST_ERASE:  if (erase_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      erase_start <= 1'b0;
      abort       <= 1'b0;
    end else begin
      state_q     <= state_d;
      erase_start <= ev_launch;
      abort       <= ev_abort;
    end
  end

  assign window_open  = in_window;
  assign erase_active = in_erase;
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sewa_pkg::*;
#(
  parameter int N_SECTORS = 8,
  parameter int CLK_MHZ   = 100,
  parameter int WIN_US    = 80,
  parameter int SEC_W     = $clog2(N_SECTORS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 se_cmd,
  input  logic [SEC_W-1:0]     se_sector,
  input  logic                 other_cmd,
  input  logic                 wr_strobe,
  input  logic                 erase_done,
  output logic [N_SECTORS-1:0] sector_mask,
  output logic                 erase_start,
  output logic                 window_open,
  output logic                 erase_active,
  output logic                 abort
);
  localparam int WIN_CYCLES = window_cycles(CLK_MHZ, WIN_US);
  localparam int CW         = count_width(WIN_CYCLES);

  logic ev_accept, ev_add, ev_restart, ev_abort, ev_launch;
  logic timer_load, timer_run, expire, mask_set, mask_clr;

  sewa_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .se_cmd      (se_cmd),
    .other_cmd   (other_cmd),
    .wr_strobe   (wr_strobe),
    .erase_done  (erase_done),
    .expire      (expire),
    .ev_accept   (ev_accept),
    .ev_add      (ev_add),
    .ev_restart  (ev_restart),
    .ev_abort    (ev_abort),
    .ev_launch   (ev_launch),
    .timer_load  (timer_load),
    .timer_run   (timer_run),
    .mask_set    (mask_set),
    .mask_clr    (mask_clr),
    .window_open (window_open),
    .erase_active(erase_active),
    .erase_start (erase_start),
    .abort       (abort)
  );

  sewa_timer #(.WIN_CYCLES(WIN_CYCLES), .CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (timer_load),
    .run   (timer_run),
    .expire(expire)
  );

  sewa_mask #(.N_SECTORS(N_SECTORS), .SEC_W(SEC_W)) u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (mask_clr),
    .set  (mask_set),
    .idx  (se_sector),
    .mask (sector_mask)
  );
endmodule

// File: rtl/sewa_checker.sv
module sewa_checker #(
  parameter int N_SECTORS = 8,
  parameter int SEC_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 se_cmd,
  input logic [SEC_W-1:0]     se_sector,
  input logic                 other_cmd,
  input logic                 wr_strobe,
  input logic                 erase_done,
  input logic [N_SECTORS-1:0] sector_mask,
  input logic                 erase_start,
  input logic                 window_open,
  input logic                 erase_active,
  input logic                 abort,
  input logic                 ev_add,
  input logic                 ev_restart
);
  // R2: first request opens the window with exactly one bit set
  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erase_active && se_cmd) |=>
      window_open && $onehot0(sector_mask) && sector_mask != '0);

  // R3: an added request only grows the mask
  a_r3_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && se_cmd && !other_cmd) |=>
      window_open && ((sector_mask & $past(sector_mask)) == $past(sector_mask))
      && sector_mask[$past(se_sector)]);

  // R4: a repeated sector leaves the mask as it was
  a_r4_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_add && sector_mask[se_sector]) |=> window_open && $stable(sector_mask));

  // R5: the start pulse is one cycle wide and follows an open window
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> erase_active && !window_open && $past(window_open));
  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R6: a bare write keeps the window open with the same mask
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_restart && !se_cmd) |=> window_open && $stable(sector_mask));

  // R7: foreign command empties the batch
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && other_cmd) |=>
      abort && sector_mask == '0 && !window_open && !erase_active && !erase_start);

  // R8: nothing disturbs a running erase
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && !erase_done) |=>
      erase_active && $stable(sector_mask) && !abort && !erase_start);

  // R9: status bit and window are never both high
  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(window_open && erase_active));

  // R10: stray inputs in idle do nothing
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erase_active && !se_cmd) |=>
      !window_open && !erase_active && sector_mask == '0 && !abort && !erase_start);

  // R1: mask is empty whenever nothing is pending
  a_r1_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erase_active) |-> sector_mask == '0);

  logic unused_ok;
  assign unused_ok = wr_strobe;
endmodule

bind sector_erase_window sewa_checker #(.N_SECTORS(N_SECTORS), .SEC_W(SEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .se_cmd      (se_cmd),
  .se_sector   (se_sector),
  .other_cmd   (other_cmd),
  .wr_strobe   (wr_strobe),
  .erase_done  (erase_done),
  .sector_mask (sector_mask),
  .erase_start (erase_start),
  .window_open (window_open),
  .erase_active(erase_active),
  .abort       (abort),
  .ev_add      (ev_add),
  .ev_restart  (ev_restart)
);

// File: tb/tb_sector_erase_window.sv
module tb_sector_erase_window;
  localparam int N   = 8;
  localparam int SW  = 3;
  localparam int MHZ = 1;
  localparam int US  = 12;
  localparam int W   = 12;  // MHZ * US

  logic clk = 1'b0, rst_n = 1'b0;
  logic se_cmd = 0, other_cmd = 0, wr_strobe = 0, erase_done = 0;
  logic [SW-1:0] se_sector = '0;
  logic [N-1:0] sector_mask;
  logic erase_start, window_open, erase_active, abort;

  always #5 clk = ~clk;

  sector_erase_window #(.N_SECTORS(N), .CLK_MHZ(MHZ), .WIN_US(US)) dut (
    .clk(clk), .rst_n(rst_n), .se_cmd(se_cmd), .se_sector(se_sector),
    .other_cmd(other_cmd), .wr_strobe(wr_strobe), .erase_done(erase_done),
    .sector_mask(sector_mask), .erase_start(erase_start),
    .window_open(window_open), .erase_active(erase_active), .abort(abort)
  );

  typedef struct packed {
    logic [N-1:0] m;
    logic o, a, s, ab;
  } snap_t;

  snap_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference state kept from the requirements: 0 idle, 1 window, 2 erase
  int ref_st = 0;
  int rem = 0;
  logic [N-1:0] rm = '0;

  task automatic cyc(input logic se, input int sec, input logic oth,
                     input logic wr, input logic dn, input string tag);
    logic rs, rab;
    @(negedge clk);
    se_cmd = se; se_sector = SW'(sec); other_cmd = oth;
    wr_strobe = wr; erase_done = dn;
    rs = 0; rab = 0;
    case (ref_st)
      0: if (se) begin rm = '0; rm[sec] = 1'b1; ref_st = 1; rem = W; end
      1: begin
        if (oth)           begin rab = 1; rm = '0; ref_st = 0; end
        else if (se)       begin rm[sec] = 1'b1; rem = W; end
        else if (wr)       rem = W;
        else if (rem == 1) begin ref_st = 2; rs = 1; end
        else               rem = rem - 1;
      end
      default: if (dn) begin ref_st = 0; rm = '0; end
    endcase
    exp_q.push_back('{m: rm, o: (ref_st == 1), a: (ref_st == 2), s: rs, ab: rab});
    tag_q.push_back(tag);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: pops one expectation per edge and compares
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        snap_t e, act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = '{m: sector_mask, o: window_open, a: erase_active, s: erase_start, ab: abort};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s: got mask=%h open=%b active=%b start=%b abort=%b, exp mask=%h open=%b active=%b start=%b abort=%b",
                   t, act.m, act.o, act.a, act.s, act.ab, e.m, e.o, e.a, e.s, e.ab);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet(1, "R1 reset state");
    cyc(0, 0, 1, 0, 0, "R10 other_cmd in idle");
    cyc(0, 0, 0, 1, 0, "R10 wr_strobe in idle");
    cyc(0, 0, 0, 0, 1, "R10 erase_done in idle");

    cyc(1, 3, 0, 0, 0, "R2 first request sector 3");
    quiet(4, "R9 window open status 0");
    cyc(1, 0, 0, 0, 0, "R3 add sector 0");
    quiet(3, "R3 window held");
    cyc(1, 3, 0, 0, 0, "R4 repeat sector 3");
    quiet(W + 1, "R5 expiry after quiet window");
    quiet(2, "R9 status 1 during erase");
    cyc(1, 6, 0, 0, 0, "R8 request ignored while erasing");
    cyc(0, 0, 1, 0, 0, "R8 other_cmd ignored while erasing");
    cyc(0, 0, 0, 1, 0, "R8 wr_strobe ignored while erasing");
    cyc(0, 0, 0, 0, 1, "R8 done clears");
    quiet(1, "R8 idle after done");

    cyc(1, 7, 0, 0, 0, "R2 first request sector 7");
    quiet(6, "R6 before restart");
    cyc(0, 0, 0, 1, 0, "R6 bare write restarts");
    quiet(W + 1, "R6 window measured from restart");
    cyc(0, 0, 0, 0, 1, "R8 done clears");

    cyc(1, 5, 0, 0, 0, "R2 first request sector 5");
    cyc(1, 1, 0, 0, 0, "R3 add sector 1");
    cyc(0, 0, 1, 0, 0, "R7 abort discards batch");
    quiet(2, "R7 idle after abort");
    cyc(1, 2, 0, 0, 0, "R2 first request sector 2");
    cyc(1, 4, 1, 0, 0, "R7 abort wins over add");
    quiet(W + 2, "R7 no erase after abort");

    for (int k = 0; k < N; k++) cyc(1, k, 0, 0, 0, "R3 fill all sectors");
    quiet(W + 1, "R5 expiry with full mask");
    cyc(0, 0, 0, 0, 1, "R8 done clears");

    cyc(1, 0, 0, 0, 0, "R2 first request sector 0");
    quiet(W - 1, "R5 window before last cycle");
    cyc(0, 0, 1, 0, 0, "R7 abort on last window cycle");
    quiet(2, "R7 no start after late abort");

    cyc(1, 6, 0, 0, 0, "R2 first request sector 6");
    quiet(W - 1, "R5 window before last cycle");
    cyc(1, 6, 0, 0, 0, "R4 repeat on last window cycle");
    quiet(W + 1, "R5 expiry after late repeat");
    cyc(0, 0, 0, 0, 1, "R8 done clears");

    @(negedge clk);
    se_cmd = 0; other_cmd = 0; wr_strobe = 0; erase_done = 0;
    @(posedge clk);
    #2;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule